// File: doc/BRIEF.md
# Multistream Fetch/Execute Stream Controller

This block keeps the status of every hardware thread context in a multistream processor and decides, each clock, which stream the instruction-fetch unit may prefetch for and which stream the execution unit may run. Every stream owns a prefetch slot that holds one instruction. A stream asks for a fetch while that slot is empty. It asks for execution while the slot is full and the stream is not waiting. Because prefetching runs across independent streams rather than deep into one, no prefetch is ever lost to a taken jump.

After an instruction of a stream starts executing, that stream is barred from prefetch for a fixed number of cycles (`EXEC_TO_FETCH`). This gives the execution unit time to resolve a jump target before the next fetch address is used. Commands create a task on a halted stream, stop a stream (halt or kill), put a stream into the waiting condition, and wake every waiting stream at once. A fixed-priority picker chooses the lowest-numbered eligible stream for each unit. A separate picker reports the lowest-numbered halted stream, so that a create request can tell whether a free context exists.

Each stream runs a four-state machine:

- `SL_HALTED`: no task is assigned.
- `SL_EMPTY`: running, with the prefetch slot empty. The stream requests a fetch.
- `SL_COOL`: running, with the slot empty, while the execute-to-fetch delay counts down.
- `SL_FULL`: running, with the slot holding an instruction. The stream requests execution unless it is waiting.

The transitions are:

- create: `SL_HALTED` to `SL_EMPTY`.
- fetch done: `SL_EMPTY` to `SL_FULL`.
- exec start: `SL_FULL` to `SL_COOL`, which loads the delay counter.
- delay expiry: `SL_COOL` to `SL_EMPTY`.
- stop: any state to `SL_HALTED`.

Top module: `stream_ctrl`

## Requirements
- R1: After reset every stream is halted. Both request vectors are zero, both grant valids are low, `free_avail` is 1 and `free_id` is 0.
- R2: A create command addressed to a halted stream makes that stream request a fetch from the next cycle. A create command addressed to a stream that is not halted has no effect.
- R3: A fetch-done event for a stream that is requesting a fetch clears its fetch request from the next cycle and raises its execute request, unless the stream is waiting. A fetch-done event for a stream that is not requesting a fetch is ignored.
- R4: An execute-start event for a stream that is requesting execution clears that request. The stream's fetch request stays low for exactly `EXEC_TO_FETCH` cycles after the start edge, then rises. An execute-start event for a stream that is not requesting execution is ignored.
- R5: A stop command returns the addressed stream to halted from the next cycle and clears its waiting bit. When a stop and a create address the same stream in the same cycle, the stop wins.
- R6: A wait-set command on a running stream masks its execute request until the waiting bit is cleared. Its fetch eligibility is not affected. A wait-set command on a halted stream is ignored.
- R7: A clear-all command clears the waiting bit of every stream in one cycle, and it wins over a wait-set in the same cycle.
- R8: `free_avail` is high exactly when some stream is halted, and `free_id` is the lowest-numbered halted stream.
- R9: Each grant names the lowest-numbered requesting stream. When no stream requests, the grant valid is low.
- R10: No stream ever requests fetch and execution at the same time, so each stream holds at most one instruction ahead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_done_valid | input | 1 | A prefetch completed |
| fetch_done_id | input | 4 | Stream the prefetch completed for |
| exec_start_valid | input | 1 | An instruction began executing |
| exec_start_id | input | 4 | Stream whose instruction began |
| create_valid | input | 1 | Create command |
| create_id | input | 4 | Stream to assign a task to |
| stop_valid | input | 1 | Halt or kill command |
| stop_id | input | 4 | Stream to return to halted |
| wait_set_valid | input | 1 | Set a stream's waiting bit |
| wait_set_id | input | 4 | Stream to put into waiting |
| wait_clr_all | input | 1 | Clear every waiting bit |
| fetch_req | output | 16 | Per-stream fetch eligibility |
| exec_req | output | 16 | Per-stream execute eligibility |
| fetch_grant_valid | output | 1 | Some stream may be fetched |
| fetch_grant_id | output | 4 | Stream chosen for fetch |
| exec_grant_valid | output | 1 | Some stream may execute |
| exec_grant_id | output | 4 | Stream chosen for execution |
| free_avail | output | 1 | A halted stream exists |
| free_id | output | 4 | Lowest-numbered halted stream |

## Verification
The properties make no assumption about when events arrive. An event aimed at an ineligible stream is defined to be ignored, so the execute-to-fetch and stop properties are conditioned only on the addressed stream's own request bit. The random stimulus mostly steers fetch-done and execute-start events at the stream currently granted, and steers creates at the reported free stream. The rest of the events go to random streams, which exercises the ignore rules as well. A reference model in the bench mirrors the per-stream state and is compared at every port once per cycle.

// File: rtl/stream_ctrl_pkg.sv
package stream_ctrl_pkg;
    typedef enum logic [1:0] {
        SL_HALTED = 2'd0,
        SL_EMPTY  = 2'd1,
        SL_COOL   = 2'd2,
        SL_FULL   = 2'd3
    } slot_state_e;
endpackage

// File: rtl/stream_slot.sv
module stream_slot
    import stream_ctrl_pkg::*;
#(
    parameter int DELAY = 1,
    parameter int CW    = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_hit,
    input  logic create_hit,
    input  logic fetch_hit,
    input  logic exec_hit,
    input  logic wset_hit,
    input  logic wclr_all,
    output logic fetch_rdy,
    output logic exec_rdy,
    output logic is_halted
);
    slot_state_e       st_q, st_n;
    logic [CW-1:0]     cnt_q, cnt_n;
    logic              wt_q, wt_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SL_HALTED;
            cnt_q <= '0;
            wt_q  <= 1'b0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            wt_q  <= wt_n;
        end
    end

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        wt_n  = wt_q;
        if (stop_hit) begin
            st_n  = SL_HALTED;
            cnt_n = '0;
            wt_n  = 1'b0;
        end else begin
            unique case (st_q)
                SL_HALTED: if (create_hit) st_n = SL_EMPTY;
                SL_EMPTY:  if (fetch_hit)  st_n = SL_FULL;
                SL_COOL: begin
                    if (cnt_q <= CW'(1)) begin
                        st_n  = SL_EMPTY;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt_q - CW'(1);
                    end
                end
                SL_FULL: begin
                    if (exec_hit && !wt_q) begin
                        st_n  = SL_COOL;
                        cnt_n = CW'(DELAY);
                    end
                end
                default: st_n = SL_HALTED;
            endcase
            if (st_q == SL_HALTED) wt_n = 1'b0;
            else if (wclr_all)     wt_n = 1'b0;
            else if (wset_hit)     wt_n = 1'b1;
        end
    end

    always_comb begin
        fetch_rdy = (st_q == SL_EMPTY);
        exec_rdy  = (st_q == SL_FULL) && !wt_q;
        is_halted = (st_q == SL_HALTED);
    end
endmodule

// File: rtl/lowest_pick.sv
module lowest_pick #(
    parameter int W  = 16,
    parameter int IW = 4
) (
    input  logic [W-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] id
);
    always_comb begin
        valid = 1'b0;
        id    = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                id    = IW'(i);
            end
        end
    end
endmodule

// File: rtl/stream_ctrl.sv
module stream_ctrl #(
    parameter int NSTREAMS      = 16,
    parameter int EXEC_TO_FETCH = 1,
    parameter int IW            = $clog2(NSTREAMS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fetch_done_valid,
    input  logic [IW-1:0]       fetch_done_id,
    input  logic                exec_start_valid,
    input  logic [IW-1:0]       exec_start_id,
    input  logic                create_valid,
    input  logic [IW-1:0]       create_id,
    input  logic                stop_valid,
    input  logic [IW-1:0]       stop_id,
    input  logic                wait_set_valid,
    input  logic [IW-1:0]       wait_set_id,
    input  logic                wait_clr_all,
    output logic [NSTREAMS-1:0] fetch_req,
    output logic [NSTREAMS-1:0] exec_req,
    output logic                fetch_grant_valid,
    output logic [IW-1:0]       fetch_grant_id,
    output logic                exec_grant_valid,
    output logic [IW-1:0]       exec_grant_id,
    output logic                free_avail,
    output logic [IW-1:0]       free_id
);
    localparam int CW = $clog2(EXEC_TO_FETCH + 1);

    logic [NSTREAMS-1:0] halted_vec;

    for (genvar g = 0; g < NSTREAMS; g++) begin : g_slot
        stream_slot #(.DELAY(EXEC_TO_FETCH), .CW(CW)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .stop_hit   (stop_valid       && (stop_id       == IW'(g))),
            .create_hit (create_valid     && (create_id     == IW'(g))),
            .fetch_hit  (fetch_done_valid && (fetch_done_id == IW'(g))),
            .exec_hit   (exec_start_valid && (exec_start_id == IW'(g))),
            .wset_hit   (wait_set_valid   && (wait_set_id   == IW'(g))),
            .wclr_all   (wait_clr_all),
            .fetch_rdy  (fetch_req[g]),
            .exec_rdy   (exec_req[g]),
            .is_halted  (halted_vec[g])
        );
    end

    lowest_pick #(.W(NSTREAMS), .IW(IW)) u_fetch_pick (
        .req(fetch_req), .valid(fetch_grant_valid), .id(fetch_grant_id));
    lowest_pick #(.W(NSTREAMS), .IW(IW)) u_exec_pick (
        .req(exec_req), .valid(exec_grant_valid), .id(exec_grant_id));
    lowest_pick #(.W(NSTREAMS), .IW(IW)) u_free_pick (
        .req(halted_vec), .valid(free_avail), .id(free_id));
endmodule

// File: rtl/stream_ctrl_chk.sv
module stream_ctrl_chk #(
    parameter int NSTREAMS = 16,
    parameter int IW       = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                exec_start_valid,
    input logic [IW-1:0]       exec_start_id,
    input logic                stop_valid,
    input logic [IW-1:0]       stop_id,
    input logic [NSTREAMS-1:0] fetch_req,
    input logic [NSTREAMS-1:0] exec_req,
    input logic                fetch_grant_valid,
    input logic [IW-1:0]       fetch_grant_id,
    input logic                exec_grant_valid,
    input logic [IW-1:0]       exec_grant_id,
    input logic                free_avail,
    input logic [IW-1:0]       free_id
);
    logic [NSTREAMS-1:0] below_f, below_e;
    assign below_f = (NSTREAMS'(1) << fetch_grant_id) - NSTREAMS'(1);
    assign below_e = (NSTREAMS'(1) << exec_grant_id) - NSTREAMS'(1);

    a_r10_one_ahead: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req & exec_req) == '0);

    a_r4_no_refetch: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_start_valid && exec_req[exec_start_id])
        |=> !fetch_req[$past(exec_start_id)] && !exec_req[$past(exec_start_id)]);

    a_r5_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stop_valid |=> !fetch_req[$past(stop_id)] && !exec_req[$past(stop_id)]);

    a_r9_fetch_pick: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_grant_valid |-> fetch_req[fetch_grant_id] && ((fetch_req & below_f) == '0));

    a_r9_exec_pick: assert property (@(posedge clk) disable iff (!rst_n)
        exec_grant_valid |-> exec_req[exec_grant_id] && ((exec_req & below_e) == '0));

    a_r9_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_grant_valid == (fetch_req == '0)) && (!exec_grant_valid == (exec_req == '0)));

    a_r8_free_idle: assert property (@(posedge clk) disable iff (!rst_n)
        free_avail |-> !fetch_req[free_id] && !exec_req[free_id]);
endmodule

bind stream_ctrl stream_ctrl_chk #(.NSTREAMS(NSTREAMS), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .exec_start_valid(exec_start_valid), .exec_start_id(exec_start_id),
    .stop_valid(stop_valid), .stop_id(stop_id),
    .fetch_req(fetch_req), .exec_req(exec_req),
    .fetch_grant_valid(fetch_grant_valid), .fetch_grant_id(fetch_grant_id),
    .exec_grant_valid(exec_grant_valid), .exec_grant_id(exec_grant_id),
    .free_avail(free_avail), .free_id(free_id)
);

// File: tb/tb_stream_ctrl.sv
module tb_stream_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 16;
    localparam int D  = 1;
    localparam int IW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fetch_done_valid = 0, exec_start_valid = 0, create_valid = 0;
    logic stop_valid = 0, wait_set_valid = 0, wait_clr_all = 0;
    logic [IW-1:0] fetch_done_id = 0, exec_start_id = 0, create_id = 0, stop_id = 0, wait_set_id = 0;
    logic [N-1:0] fetch_req, exec_req;
    logic fetch_grant_valid, exec_grant_valid, free_avail;
    logic [IW-1:0] fetch_grant_id, exec_grant_id, free_id;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // model: 0 halted, 1 empty, 2 cooling, 3 full
    int ms[N];
    int mc[N];
    bit mw[N];

    always #(CLK_PERIOD/2) clk = ~clk;

    stream_ctrl #(.NSTREAMS(N), .EXEC_TO_FETCH(D)) dut (.*);

    function automatic logic [N-1:0] exp_fetch();
        logic [N-1:0] v = '0;
        for (int i = 0; i < N; i++) v[i] = (ms[i] == 1);
        return v;
    endfunction

    function automatic logic [N-1:0] exp_exec();
        logic [N-1:0] v = '0;
        for (int i = 0; i < N; i++) v[i] = (ms[i] == 3) && !mw[i];
        return v;
    endfunction

    function automatic logic [N-1:0] exp_halted();
        logic [N-1:0] v = '0;
        for (int i = 0; i < N; i++) v[i] = (ms[i] == 0);
        return v;
    endfunction

    function automatic int lowest(logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic [N-1:0] ef = exp_fetch();
        logic [N-1:0] ee = exp_exec();
        int lf = lowest(ef);
        int le = lowest(ee);
        int lh = lowest(exp_halted());
        check(fetch_req === ef, "R4 fetch_req", fetch_req, ef);
        check(exec_req === ee, "R3 exec_req", exec_req, ee);
        check((fetch_req & exec_req) == '0, "R10 overlap", fetch_req & exec_req, 0);
        check(fetch_grant_valid === (lf >= 0), "R9 fetch_grant_valid", fetch_grant_valid, lf >= 0);
        if (lf >= 0) check(fetch_grant_id == IW'(lf), "R9 fetch_grant_id", fetch_grant_id, lf);
        check(exec_grant_valid === (le >= 0), "R9 exec_grant_valid", exec_grant_valid, le >= 0);
        if (le >= 0) check(exec_grant_id == IW'(le), "R9 exec_grant_id", exec_grant_id, le);
        check(free_avail === (lh >= 0), "R8 free_avail", free_avail, lh >= 0);
        if (lh >= 0) check(free_id == IW'(lh), "R8 free_id", free_id, lh);
    endtask

    task automatic model_apply();
        for (int i = 0; i < N; i++) begin
            if (stop_valid && stop_id == IW'(i)) begin
                ms[i] = 0; mc[i] = 0; mw[i] = 0;
            end else begin
                bit was_halted = (ms[i] == 0);
                case (ms[i])
                    0: if (create_valid && create_id == IW'(i)) ms[i] = 1;
                    1: if (fetch_done_valid && fetch_done_id == IW'(i)) ms[i] = 3;
                    2: if (mc[i] <= 1) begin ms[i] = 1; mc[i] = 0; end else mc[i]--;
                    default: if (exec_start_valid && exec_start_id == IW'(i) && !mw[i]) begin
                        ms[i] = 2; mc[i] = D;
                    end
                endcase
                if (was_halted) mw[i] = 0;
                else if (wait_clr_all) mw[i] = 0;
                else if (wait_set_valid && wait_set_id == IW'(i)) mw[i] = 1;
            end
        end
    endtask

    task automatic clear_inputs();
        fetch_done_valid = 0; exec_start_valid = 0; create_valid = 0;
        stop_valid = 0; wait_set_valid = 0; wait_clr_all = 0;
    endtask

    task automatic tick();
        model_apply();
        @(negedge clk);
        check_all();
        clear_inputs();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int r;
        r = $urandom(32'h5eed_1234);
        for (int i = 0; i < N; i++) begin ms[i] = 0; mc[i] = 0; mw[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(fetch_req == '0 && exec_req == '0, "R1 requests", {fetch_req, exec_req}, 0);
        check(!fetch_grant_valid && !exec_grant_valid, "R1 grants", {fetch_grant_valid, exec_grant_valid}, 0);
        check(free_avail && free_id == 0, "R1 free", {free_avail, free_id}, 16);
        check_all();

        // R2 create on halted streams
        create_valid = 1; create_id = 3; tick();
        check(fetch_req[3] == 1, "R2 create", fetch_req[3], 1);
        create_valid = 1; create_id = 5; tick();
        // R3 ignored fetch-done on halted stream 7
        fetch_done_valid = 1; fetch_done_id = 7; tick();
        check(exec_req[7] == 0, "R3 ignore", exec_req[7], 0);
        // fetch for 3
        fetch_done_valid = 1; fetch_done_id = 3; tick();
        check(exec_req[3] == 1 && fetch_req[3] == 0, "R3 fetch", {exec_req[3], fetch_req[3]}, 2);
        // R2 create on running stream ignored
        create_valid = 1; create_id = 3; tick();
        check(exec_req[3] == 1 && fetch_req[3] == 0, "R2 ignore", {exec_req[3], fetch_req[3]}, 2);
        // R4 execute start then delay
        exec_start_valid = 1; exec_start_id = 3; tick();
        check(fetch_req[3] == 0 && exec_req[3] == 0, "R4 delay", {fetch_req[3], exec_req[3]}, 0);
        tick();
        check(fetch_req[3] == 1, "R4 reopen", fetch_req[3], 1);
        // R4 ignored exec-start on empty stream 5
        exec_start_valid = 1; exec_start_id = 5; tick();
        check(fetch_req[5] == 1, "R4 ignore", fetch_req[5], 1);
        // R6 wait masks execute, not fetch
        fetch_done_valid = 1; fetch_done_id = 5; wait_set_valid = 1; wait_set_id = 3; tick();
        check(fetch_req[3] == 1, "R6 fetch kept", fetch_req[3], 1);
        fetch_done_valid = 1; fetch_done_id = 3; tick();
        check(exec_req[3] == 0 && exec_req[5] == 1, "R6 masked", {exec_req[3], exec_req[5]}, 1);
        // R7 clear-all wins over wait-set
        wait_clr_all = 1; wait_set_valid = 1; wait_set_id = 5; tick();
        check(exec_req[3] == 1 && exec_req[5] == 1, "R7 clear", {exec_req[3], exec_req[5]}, 3);
        // R5 stop beats create same stream
        stop_valid = 1; stop_id = 3; create_valid = 1; create_id = 3; tick();
        check(!fetch_req[3] && !exec_req[3] && free_id == 0, "R5 stop", {fetch_req[3], exec_req[3]}, 0);
        // R6 wait-set on halted ignored: create afterwards runs free
        wait_set_valid = 1; wait_set_id = 3; tick();
        create_valid = 1; create_id = 3; tick();
        fetch_done_valid = 1; fetch_done_id = 3; tick();
        check(exec_req[3] == 1, "R6 halted ignore", exec_req[3], 1);
        // R8 fill every stream
        for (int k = 0; k < N; k++) begin
            create_valid = 1; create_id = free_id; tick();
        end
        check(!free_avail, "R8 none free", free_avail, 0);
        stop_valid = 1; stop_id = 9; tick();
        check(free_avail && free_id == 9, "R8 one free", free_id, 9);
        // R9 no requests after stopping all
        for (int k = 0; k < N; k++) begin
            stop_valid = 1; stop_id = IW'(k); tick();
        end
        check(!fetch_grant_valid && !exec_grant_valid, "R9 idle", {fetch_grant_valid, exec_grant_valid}, 0);

        // random phase
        for (int c = 0; c < 4000; c++) begin
            if ($urandom % 6 == 0) begin
                create_valid = 1;
                create_id = ($urandom % 4 == 0) ? IW'($urandom) : free_id;
            end
            if ($urandom % 10 < 7) begin
                fetch_done_valid = 1;
                fetch_done_id = ($urandom % 8 == 0 || !fetch_grant_valid) ? IW'($urandom) : fetch_grant_id;
            end
            if ($urandom % 10 < 7) begin
                exec_start_valid = 1;
                exec_start_id = ($urandom % 8 == 0 || !exec_grant_valid) ? IW'($urandom) : exec_grant_id;
            end
            if ($urandom % 25 == 0) begin stop_valid = 1; stop_id = IW'($urandom); end
            if ($urandom % 15 == 0) begin wait_set_valid = 1; wait_set_id = IW'($urandom); end
            if ($urandom % 30 == 0) wait_clr_all = 1;
            tick();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule